// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block decides, for every memory access that falls into the legacy area below 1 MB, whether the read or the write is served by DRAM or forwarded to the PCI bus. Software programs a set of attribute bytes through a byte-wide configuration write port. Each attribute nibble carries a read-enable and a write-enable bit for one shadowable region. The top 64 KB firmware area is one region. Below it lie twelve 16 KB expansion regions starting at 0xC0000. Seven attribute bytes cover these thirteen regions: the firmware region has the second nibble of the first byte, and each later byte serves two expansion regions.

A separate system-management control byte governs the 128 KB window at 0xA0000–0xBFFFF. Ordinary accesses reach DRAM there only when the window is opened. Accesses made in system-management mode also reach DRAM when the protected-RAM enable bit is set. Addresses at or above the top of memory always go to PCI. Every other address below the top goes to DRAM.

The decode is purely combinational from the access inputs and the stored configuration. A configuration write changes the routing from the cycle after the clock edge that captures it.

Top module: `shmem_attr_decoder`

## Requirements
- R1: The select encoding is bit 0 = DRAM and bit 1 = PCI. When `acc_wr` is 0, `rd_sel` carries exactly one set bit and `wr_sel` is 00. When `acc_wr` is 1, the roles swap.
- R2: After reset every attribute byte is 0x00, so all thirteen regions forward both reads and writes to PCI. The system-management byte is 0x02, so the window goes to PCI in both modes.
- R3: Region 0 covers 0xF0000–0xFFFFF. Region i, for i from 1 to 12, covers 0xC0000+(i-1)*0x4000 for 16 KB. Region i uses the attribute byte at offset 0x59+((i+1)/2). Region 0 and even regions use bits 7:4 of that byte; odd regions use bits 3:0.
- R4: Within a region's nibble, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. A clear bit sends that direction to PCI.
- R5: For accesses with `acc_smm`=0 in 0xA0000–0xBFFFF, both directions go to DRAM exactly when bit 6 (open) of the byte at offset 0x72 is set, and to PCI otherwise.
- R6: For accesses with `acc_smm`=1 in 0xA0000–0xBFFFF, both directions go to DRAM when bit 3 (enable) or bit 6 (open) of offset 0x72 is set, and to PCI otherwise.
- R7: A configuration write changes the routing from the cycle after the capturing clock edge, not before it. Writes to any offset other than 0x59–0x5F and 0x72 change no routing.
- R8: Addresses at or above TOP_OF_MEM (default 0x0800_0000) go to PCI. Addresses below it that lie outside the window and outside all regions go to DRAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| acc_addr | input | ADDR_W | Memory access address |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_smm | input | 1 | Access made in system-management mode |
| rd_sel | output | 2 | Read target: 01 DRAM, 10 PCI, 00 when writing |
| wr_sel | output | 2 | Write target: 01 DRAM, 10 PCI, 00 when reading |

## Verification
A wrong stored attribute nibble or control bit is silent until an access lands in the affected region. Once such an access arrives, the wrong target appears on the select outputs in the same cycle. The bench therefore probes region edges, the first and last byte of every class, and both modes of the window right after each programming write. It also probes one cycle earlier, with the write still pending, to catch routing that changes too soon. A misdecoded byte or nibble index shows up as the neighbouring region changing instead of the programmed one.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'b00,
      SEL_DRAM = 2'b01,
      SEL_PCI  = 2'b10
   } tgt_sel_e;

   function automatic tgt_sel_e route_of(input logic to_dram);
      return to_dram ? SEL_DRAM : SEL_PCI;
   endfunction
endpackage

// File: rtl/shmem_cfg_regs.sv
module shmem_cfg_regs #(
   parameter int          NUM_ATTR  = 7,
   parameter logic [7:0]  ATTR_BASE = 8'h59,
   parameter logic [7:0]  SMRAM_OFS = 8'h72,
   parameter logic [7:0]  SMRAM_RST = 8'h02
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [7:0]            cfg_addr,
   input  logic [7:0]            cfg_wdata,
   output logic [NUM_ATTR*8-1:0] attr_flat,
   output logic [7:0]            smram_q
);
   for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
      localparam logic [7:0] K_OFS = ATTR_BASE + 8'(k);
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            byte_q <= 8'h00;
         else if (cfg_we && cfg_addr == K_OFS)
            byte_q <= cfg_wdata;
      end
      assign attr_flat[k*8 +: 8] = byte_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         smram_q <= SMRAM_RST;
      else if (cfg_we && cfg_addr == SMRAM_OFS)
         smram_q <= cfg_wdata;
   end
endmodule

// File: rtl/shmem_region_map.sv
module shmem_region_map #(
   parameter int                ADDR_W    = 32,
   parameter int                NUM_EXP   = 12,
   parameter int                NUM_ATTR  = 7,
   parameter int                RE_BIT    = 0,
   parameter int                WE_BIT    = 1,
   parameter logic [ADDR_W-1:0] EXP_BASE  = 'h000C_0000,
   parameter logic [ADDR_W-1:0] EXP_SIZE  = 'h0000_4000,
   parameter logic [ADDR_W-1:0] BIOS_BASE = 'h000F_0000,
   parameter logic [ADDR_W-1:0] BIOS_SIZE = 'h0001_0000
) (
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [NUM_ATTR*8-1:0] attr_flat,
   output logic                  any_hit,
   output logic                  hit_rd_dram,
   output logic                  hit_wr_dram
);
   localparam int NUM_REG = NUM_EXP + 1;

   logic [ADDR_W:0]  a_ext;
   logic [NUM_REG-1:0] hit_v, re_v, we_v;

   assign a_ext = {1'b0, acc_addr};

   for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
      localparam int BYTE_IX = (i + 1) / 2;
      localparam int NIB_LSB = BYTE_IX * 8 + (((i % 2) == 1) ? 0 : 4);
      logic [ADDR_W:0] lo, hi;
      if (i == 0) begin : g_bios
         assign lo = {1'b0, BIOS_BASE};
         assign hi = {1'b0, BIOS_BASE} + {1'b0, BIOS_SIZE};
      end else begin : g_exp
         localparam logic [ADDR_W:0] IDX = (ADDR_W+1)'(i - 1);
         assign lo = {1'b0, EXP_BASE} + IDX * {1'b0, EXP_SIZE};
         assign hi = lo + {1'b0, EXP_SIZE};
      end
      assign hit_v[i] = (a_ext >= lo) && (a_ext < hi);
      assign re_v[i]  = attr_flat[NIB_LSB + RE_BIT];
      assign we_v[i]  = attr_flat[NIB_LSB + WE_BIT];
   end

   assign any_hit     = |hit_v;
   assign hit_rd_dram = |(hit_v & re_v);
   assign hit_wr_dram = |(hit_v & we_v);
endmodule

// File: rtl/shmem_smram_gate.sv
module shmem_smram_gate #(
   parameter int                ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE    = 'h000A_0000,
   parameter logic [ADDR_W-1:0] WIN_SIZE    = 'h0002_0000,
   parameter int                OPEN_BIT    = 6,
   parameter int                EN_BIT      = 3,
   parameter bit                SMM_FALLBACK = 1'b1
) (
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   input  logic [7:0]        smram_q,
   output logic              in_win,
   output logic              win_dram
);
   logic [ADDR_W:0] a_ext;
   assign a_ext  = {1'b0, acc_addr};
   assign in_win = (a_ext >= {1'b0, WIN_BASE}) &&
                   (a_ext <  {1'b0, WIN_BASE} + {1'b0, WIN_SIZE});

   if (SMM_FALLBACK) begin : g_fallback
      // protected view overlays the normal view, which follows the open bit
      assign win_dram = smram_q[OPEN_BIT] | (acc_smm & smram_q[EN_BIT]);
   end else begin : g_strict
      assign win_dram = acc_smm ? smram_q[EN_BIT] : smram_q[OPEN_BIT];
   end
endmodule

// File: rtl/shmem_attr_decoder.sv
module shmem_attr_decoder
   import shmem_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                NUM_EXP    = 12,
   parameter logic [ADDR_W-1:0] EXP_BASE   = 'h000C_0000,
   parameter logic [ADDR_W-1:0] EXP_SIZE   = 'h0000_4000,
   parameter logic [ADDR_W-1:0] BIOS_BASE  = 'h000F_0000,
   parameter logic [ADDR_W-1:0] BIOS_SIZE  = 'h0001_0000,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 'h000A_0000,
   parameter logic [ADDR_W-1:0] WIN_SIZE   = 'h0002_0000,
   parameter logic [ADDR_W-1:0] TOP_OF_MEM = 'h0800_0000,
   parameter logic [7:0]        ATTR_BASE  = 8'h59,
   parameter logic [7:0]        SMRAM_OFS  = 8'h72,
   parameter logic [7:0]        SMRAM_RST  = 8'h02,
   parameter int                OPEN_BIT   = 6,
   parameter int                EN_BIT     = 3,
   parameter bit                SMM_FALLBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_wr,
   input  logic              acc_smm,
   output logic [1:0]        rd_sel,
   output logic [1:0]        wr_sel
);
   localparam int NUM_ATTR = (NUM_EXP + 1) / 2 + 1;
   localparam logic [ADDR_W:0] EXP_END =
      {1'b0, EXP_BASE} + (ADDR_W+1)'(NUM_EXP) * {1'b0, EXP_SIZE};

   if (EXP_END > {1'b0, BIOS_BASE}) begin : g_bad_layout
      $error("expansion regions run into the firmware region");
   end
   if ({1'b0, WIN_BASE} + {1'b0, WIN_SIZE} > {1'b0, EXP_BASE}) begin : g_bad_win
      $error("protected window overlaps the expansion regions");
   end
   if (SMRAM_OFS >= ATTR_BASE && SMRAM_OFS < ATTR_BASE + 8'(NUM_ATTR)) begin : g_bad_ofs
      $error("control byte offset collides with attribute bytes");
   end
   if (OPEN_BIT > 7 || EN_BIT > 7 || OPEN_BIT == EN_BIT) begin : g_bad_bits
      $error("control bit positions invalid");
   end

   logic [NUM_ATTR*8-1:0] attr_flat;
   logic [7:0]            smram_q;
   logic                  any_hit, hit_rd_dram, hit_wr_dram;
   logic                  in_win, win_dram, above_top;
   logic                  to_dram_rd, to_dram_wr;

   shmem_cfg_regs #(
      .NUM_ATTR (NUM_ATTR),
      .ATTR_BASE(ATTR_BASE),
      .SMRAM_OFS(SMRAM_OFS),
      .SMRAM_RST(SMRAM_RST)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .attr_flat(attr_flat),
      .smram_q  (smram_q)
   );

   shmem_region_map #(
      .ADDR_W   (ADDR_W),
      .NUM_EXP  (NUM_EXP),
      .NUM_ATTR (NUM_ATTR),
      .RE_BIT   (0),
      .WE_BIT   (1),
      .EXP_BASE (EXP_BASE),
      .EXP_SIZE (EXP_SIZE),
      .BIOS_BASE(BIOS_BASE),
      .BIOS_SIZE(BIOS_SIZE)
   ) u_map (
      .acc_addr   (acc_addr),
      .attr_flat  (attr_flat),
      .any_hit    (any_hit),
      .hit_rd_dram(hit_rd_dram),
      .hit_wr_dram(hit_wr_dram)
   );

   shmem_smram_gate #(
      .ADDR_W      (ADDR_W),
      .WIN_BASE    (WIN_BASE),
      .WIN_SIZE    (WIN_SIZE),
      .OPEN_BIT    (OPEN_BIT),
      .EN_BIT      (EN_BIT),
      .SMM_FALLBACK(SMM_FALLBACK)
   ) u_win (
      .acc_addr(acc_addr),
      .acc_smm (acc_smm),
      .smram_q (smram_q),
      .in_win  (in_win),
      .win_dram(win_dram)
   );

   assign above_top = acc_addr >= TOP_OF_MEM;

   always_comb begin
      if (above_top) begin
         to_dram_rd = 1'b0;
         to_dram_wr = 1'b0;
      end else if (in_win) begin
         to_dram_rd = win_dram;
         to_dram_wr = win_dram;
      end else if (any_hit) begin
         to_dram_rd = hit_rd_dram;
         to_dram_wr = hit_wr_dram;
      end else begin
         to_dram_rd = 1'b1;
         to_dram_wr = 1'b1;
      end
   end

   assign rd_sel = acc_wr ? SEL_NONE : route_of(to_dram_rd);
   assign wr_sel = acc_wr ? route_of(to_dram_wr) : SEL_NONE;
endmodule

// File: rtl/shmem_attr_decoder_chk.sv
module shmem_attr_decoder_chk #(
   parameter int                ADDR_W     = 32,
   parameter int                NUM_ATTR   = 7,
   parameter logic [7:0]        ATTR_BASE  = 8'h59,
   parameter logic [7:0]        SMRAM_OFS  = 8'h72,
   parameter logic [7:0]        SMRAM_RST  = 8'h02,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 'h000A_0000,
   parameter logic [ADDR_W-1:0] WIN_SIZE   = 'h0002_0000,
   parameter logic [ADDR_W-1:0] TOP_OF_MEM = 'h0800_0000,
   parameter int                OPEN_BIT   = 6,
   parameter int                EN_BIT     = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic [7:0]            cfg_addr,
   input logic [ADDR_W-1:0]     acc_addr,
   input logic                  acc_wr,
   input logic                  acc_smm,
   input logic [1:0]            rd_sel,
   input logic [1:0]            wr_sel,
   input logic [NUM_ATTR*8-1:0] attr_flat,
   input logic [7:0]            smram_q
);
   logic [ADDR_W:0] a_ext;
   logic win_c, above_c, cfg_hit_c;
   logic [1:0] any_sel;

   assign a_ext     = {1'b0, acc_addr};
   assign win_c     = a_ext >= {1'b0, WIN_BASE} &&
                      a_ext <  {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};
   assign above_c   = a_ext >= {1'b0, TOP_OF_MEM};
   assign cfg_hit_c = cfg_we && ((cfg_addr >= ATTR_BASE &&
                      cfg_addr < ATTR_BASE + 8'(NUM_ATTR)) || cfg_addr == SMRAM_OFS);
   assign any_sel   = rd_sel | wr_sel;

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rd_sel, wr_sel}) == 1); // R1
   AST_RD_QUIET_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr |-> rd_sel == 2'b00); // R1
   AST_RST_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> smram_q == SMRAM_RST); // R2
   AST_WIN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (win_c && !acc_smm && !smram_q[OPEN_BIT]) |-> any_sel == 2'b10); // R5
   AST_SMM_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
      (win_c && acc_smm && smram_q[EN_BIT]) |-> any_sel == 2'b01); // R6
   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_hit_c |=> ($stable(attr_flat) && $stable(smram_q))); // R7
   AST_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      above_c |-> any_sel == 2'b10); // R8
endmodule

bind shmem_attr_decoder shmem_attr_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .NUM_ATTR  (NUM_ATTR),
   .ATTR_BASE (ATTR_BASE),
   .SMRAM_OFS (SMRAM_OFS),
   .SMRAM_RST (SMRAM_RST),
   .WIN_BASE  (WIN_BASE),
   .WIN_SIZE  (WIN_SIZE),
   .TOP_OF_MEM(TOP_OF_MEM),
   .OPEN_BIT  (OPEN_BIT),
   .EN_BIT    (EN_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .acc_addr (acc_addr),
   .acc_wr   (acc_wr),
   .acc_smm  (acc_smm),
   .rd_sel   (rd_sel),
   .wr_sel   (wr_sel),
   .attr_flat(attr_flat),
   .smram_q  (smram_q)
);

// File: tb/shmem_attr_decoder_bench.sv
module shmem_attr_decoder_bench;
   localparam logic [31:0] TOP = 32'h0800_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [31:0] acc_addr = 32'h0;
   logic        acc_wr = 1'b0;
   logic        acc_smm = 1'b0;
   logic [1:0]  rd_sel, wr_sel;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] m_attr [7];
   logic [7:0] m_ctl;

   always #4 clk = ~clk;

   shmem_attr_decoder u_shmem_attr_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_wr(acc_wr),
      .acc_smm(acc_smm), .rd_sel(rd_sel), .wr_sel(wr_sel)
   );

   // expected {wr_sel, rd_sel}; 01 = DRAM, 10 = PCI
   function automatic logic [3:0] exp_sel(input logic [31:0] a, input logic w, input logic s);
      logic dr, dw;
      logic [3:0] nib;
      int r, b;
      dr = 1'b1; dw = 1'b1;
      if (a >= TOP) begin
         dr = 1'b0; dw = 1'b0;
      end else if (a >= 32'hA0000 && a < 32'hC0000) begin
         dr = s ? (m_ctl[3] | m_ctl[6]) : m_ctl[6];
         dw = dr;
      end else if (a >= 32'hF0000 && a < 32'h100000) begin
         dr = m_attr[0][4]; dw = m_attr[0][5];
      end else if (a >= 32'hC0000 && a < 32'hF0000) begin
         r = int'((a - 32'hC0000) / 32'h4000) + 1;
         b = (r + 1) / 2;
         nib = (r % 2 == 1) ? m_attr[b][3:0] : m_attr[b][7:4];
         dr = nib[0]; dw = nib[1];
      end
      if (w) return {(dw ? 2'b01 : 2'b10), 2'b00};
      return {2'b00, (dr ? 2'b01 : 2'b10)};
   endfunction

   function automatic string req_of(input logic [31:0] a, input logic s);
      if (a >= TOP) return "R8";
      if (a >= 32'hA0000 && a < 32'hC0000) return s ? "R6" : "R5";
      if (a >= 32'hC0000 && a < 32'h100000) return "R3";
      return "R8";
   endfunction

   task automatic compare(input string req);
      logic [3:0] got, exp;
      got = {wr_sel, rd_sel};
      exp = exp_sel(acc_addr, acc_wr, acc_smm);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s addr=%h wr=%0b smm=%0b got=%b exp=%b",
                  req, acc_addr, acc_wr, acc_smm, got, exp);
      end
   endtask

   task automatic probe(input logic [31:0] a, input logic w, input logic s, input string req);
      @(negedge clk);
      acc_addr = a; acc_wr = w; acc_smm = s;
      #1;
      compare(req);
   endtask

   task automatic model_wr(input logic [7:0] ofs, input logic [7:0] d);
      if (ofs >= 8'h59 && ofs <= 8'h5F) m_attr[ofs - 8'h59] = d;
      if (ofs == 8'h72) m_ctl = d;
   endtask

   task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_wr(ofs, d);
   endtask

   function automatic logic [31:0] rand_addr();
      case ($urandom % 6)
         0: return 32'hA0000 + ($urandom % 32'h20000);
         1: return 32'hC0000 + ($urandom % 32'h40000);
         2: return $urandom % 32'hA0000;
         3: return TOP + ($urandom % 32'h100);
         4: return TOP - 32'd1 - ($urandom % 32'h100);
         default: return 32'h100000 + ($urandom % (TOP - 32'h100000));
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int k = 0; k < 7; k++) m_attr[k] = 8'h00;
      m_ctl = 8'h02;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      probe(32'hF0000, 1'b0, 1'b0, "R2");
      probe(32'hC0000, 1'b1, 1'b0, "R2");
      probe(32'hA0000, 1'b0, 1'b1, "R2");
      probe(32'hBFFFF, 1'b1, 1'b0, "R2");
      probe(32'h00001000, 1'b0, 1'b0, "R8");
      // R1 write access leaves read select idle
      probe(32'h00002000, 1'b1, 1'b0, "R1");

      // R4 read/write enable bits on region 0
      cfg_write(8'h59, 8'h10);
      probe(32'hF8000, 1'b0, 1'b0, "R4");
      probe(32'hF8000, 1'b1, 1'b0, "R4");
      cfg_write(8'h59, 8'h20);
      probe(32'hFFFFF, 1'b0, 1'b0, "R4");
      probe(32'hFFFFF, 1'b1, 1'b0, "R4");

      // R3 nibble and byte mapping
      cfg_write(8'h5A, 8'h21);
      probe(32'hC0000, 1'b0, 1'b0, "R3");
      probe(32'hC3FFF, 1'b0, 1'b0, "R3");
      probe(32'hC4000, 1'b0, 1'b0, "R3");
      probe(32'hC4000, 1'b1, 1'b0, "R3");
      probe(32'hC3FFF, 1'b1, 1'b0, "R3");
      probe(32'hC8000, 1'b1, 1'b0, "R3");
      cfg_write(8'h5F, 8'h03);
      probe(32'hE8000, 1'b0, 1'b0, "R3");
      probe(32'hEBFFF, 1'b1, 1'b0, "R3");
      probe(32'hEC000, 1'b0, 1'b0, "R3");
      probe(32'hEFFFF, 1'b1, 1'b0, "R3");
      probe(32'hF0000, 1'b0, 1'b0, "R3");

      // R7 write not visible before its edge, visible after
      @(negedge clk);
      acc_addr = 32'hA8000; acc_wr = 1'b0; acc_smm = 1'b0;
      cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h40;
      #1;
      compare("R7");
      @(negedge clk);
      cfg_we = 1'b0;
      model_wr(8'h72, 8'h40);
      #1;
      compare("R7");

      // R5 / R6 window
      probe(32'hBFFFF, 1'b1, 1'b0, "R5");
      probe(32'hA0000, 1'b0, 1'b1, "R6");
      cfg_write(8'h72, 8'h08);
      probe(32'hA0000, 1'b0, 1'b0, "R5");
      probe(32'hBFFFF, 1'b1, 1'b1, "R6");
      probe(32'h9FFFF, 1'b0, 1'b0, "R8");
      cfg_write(8'h72, 8'h00);
      probe(32'hB0000, 1'b0, 1'b1, "R6");
      probe(32'hB0000, 1'b1, 1'b0, "R5");

      // R7 writes outside the programmable offsets are ignored
      cfg_write(8'h58, 8'hFF);
      cfg_write(8'h60, 8'hFF);
      cfg_write(8'h71, 8'hFF);
      cfg_write(8'h73, 8'hFF);
      probe(32'hF4000, 1'b0, 1'b0, "R7");
      probe(32'hEC000, 1'b1, 1'b0, "R7");
      probe(32'hA4000, 1'b0, 1'b1, "R7");
      probe(32'hA4000, 1'b1, 1'b0, "R7");

      // R8 top of memory boundary
      probe(TOP - 32'd1, 1'b0, 1'b0, "R8");
      probe(TOP, 1'b0, 1'b0, "R8");
      probe(TOP, 1'b1, 1'b1, "R8");
      probe(32'h100000, 1'b1, 1'b0, "R8");

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         if ($urandom % 4 == 0) begin
            logic [7:0] ofs;
            case ($urandom % 4)
               0: ofs = 8'h59 + 8'($urandom % 7);
               1: ofs = 8'h72;
               2: ofs = 8'($urandom);
               default: ofs = ($urandom % 2 == 0) ? 8'h58 : 8'h60;
            endcase
            cfg_write(ofs, 8'($urandom));
         end else begin
            logic [31:0] a;
            logic s;
            a = rand_addr();
            s = 1'($urandom);
            probe(a, 1'($urandom), s, req_of(a, s));
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule